// File: doc/BRIEF.md
# Fixed-Latency Group Timing Controller

This block sequences one fixed-latency group of work. The group lasts a number of cycles fixed at elaboration. A start request launches the group, and an internal relative cycle index then runs from zero up to the final cycle. From that index the block decodes a vector of timing guards. Each guard is configured as a half-open window `[lo, hi)`. A guard is high only while the group is running and the index lies inside its window. The surrounding datapath uses these guards to gate its operand selects, start strobes and register write enables. The block never waits on a completion signal from the work it schedules.

The windows are given as parameter arrays. A window whose upper bound is above the group length, or whose lower bound is above its upper bound, stops elaboration with an error. A window with equal bounds never fires. A group built only from such windows therefore does no datapath work and acts as a plain delay of its full length.

The default configuration models a four-cycle group. Guard 0 covers `[0,3)`, which is enough to drive the operands and start strobe of a three-cycle multiplier. Guard 1 covers `[3,4)` and writes the product into a result register in the final cycle. Guard 2 covers `[2,2)` and is empty.

Top module: `static_group_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy` is 0, `cycle_idx` is 0, `last_cycle` is 0 and every bit of `guard` is 0.
- R2: When `start` is 1 at a rising clock edge while `busy` is 0, the next cycle has `busy` = 1 and `cycle_idx` = 0.
- R3: While `busy` is 1 and `last_cycle` is 0, `cycle_idx` rises by exactly one at each edge. Without a new start, a group is therefore busy for exactly LATENCY cycles, with indices 0 to LATENCY-1.
- R4: `last_cycle` is 1 exactly when `busy` is 1 and `cycle_idx` = LATENCY-1. If `start` is 0 in that cycle, `busy` is 0 in the next cycle.
- R5: Bit g of `guard` is 1 exactly when `busy` is 1 and GUARD_LO[g] <= `cycle_idx` < GUARD_HI[g].
- R6: A window with GUARD_HI = GUARD_LO + 1 is high for exactly one cycle per group. A window with GUARD_HI = GUARD_LO is never high, and the group still lasts LATENCY cycles (defaults: bit 1 = [3,4), bit 2 = [2,2)).
- R7: When `start` is 1 during the last cycle, the next cycle has `busy` = 1 and `cycle_idx` = 0, with no idle cycle between the groups.
- R8: A `start` of 1 in a busy cycle that is not the last cycle has no effect: the index keeps counting and the group ends on schedule.
- R9: While `busy` is 0, every bit of `guard` is 0, whatever `start` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, sampled at the rising edge |
| busy | output | 1 | A group is in progress |
| cycle_idx | output | CW | Relative cycle index within the group |
| last_cycle | output | 1 | Final cycle of the group |
| guard | output | NUM_GUARDS | Per-window timing guards |

CW is `$clog2(LATENCY)`, with a minimum of 1.

## Verification
A stuck or skipped count value moves every guard window. The result is a write enable that fires a cycle early or late, or never fires, and it shows within one group of the faulty launch. A busy flag left set after the final cycle shows as guards firing during idle on the very next cycle. A lost relaunch shows as a one-cycle gap in `busy` between back-to-back groups. Comparing the ports cycle by cycle with an independent model therefore exposes any such fault within LATENCY cycles.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

  // Width of the relative cycle index for a group of n cycles (at least one bit).
  function automatic int unsigned sgs_count_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // True when relative cycle c lies in the half-open window [lo, hi).
  function automatic bit sgs_in_window(input int unsigned c,
                                       input int unsigned lo,
                                       input int unsigned hi);
    return (c >= lo) && (c < hi);
  endfunction

  // A window is legal when it is ordered and fits inside the group.
  function automatic bit sgs_window_legal(input int unsigned lo,
                                          input int unsigned hi,
                                          input int unsigned n);
    return (lo <= hi) && (hi <= n);
  endfunction

  // Kind of decoder a window needs.
  typedef enum logic [1:0] {
    WIN_EMPTY  = 2'd0,
    WIN_SINGLE = 2'd1,
    WIN_RANGE  = 2'd2
  } sgs_win_kind_e;

  function automatic sgs_win_kind_e sgs_window_kind(input int unsigned lo,
                                                    input int unsigned hi);
    if (hi == lo)     return WIN_EMPTY;
    if (hi == lo + 1) return WIN_SINGLE;
    return WIN_RANGE;
  endfunction

endpackage

// File: rtl/sgs_cycle_counter.sv
module sgs_cycle_counter #(
  parameter int unsigned LATENCY = 4,
  localparam int unsigned CW = sgs_pkg::sgs_count_width(LATENCY)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic [CW-1:0] idx_o,
  output logic          last_o,
  output logic          launch_o,
  output logic          finish_o
);

  localparam logic [CW-1:0] LAST_IDX = CW'(LATENCY - 1);

  logic          busy_q;
  logic [CW-1:0] idx_q;

  // Named events, brought out for the checks in the top module.
  assign last_o   = busy_q && (idx_q == LAST_IDX);
  assign launch_o = start_i && (!busy_q || last_o);
  assign finish_o = last_o && !start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (launch_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (finish_o) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (busy_q) begin
      idx_q  <= idx_q + CW'(1);
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;

  // R3: a running, non-final cycle always steps the index by one.
  a_r3_index_step : assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_o) |=> (busy_q && idx_q == $past(idx_q) + CW'(1)));

  // R1: the idle index rests at zero.
  a_r1_idle_zero : assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (idx_q == '0));

endmodule

// File: rtl/sgs_guard_window.sv
module sgs_guard_window #(
  parameter int unsigned LATENCY = 4,
  parameter int unsigned LO      = 0,
  parameter int unsigned HI      = 1,
  localparam int unsigned CW = sgs_pkg::sgs_count_width(LATENCY)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic [CW-1:0] idx_i,
  output logic          hit_o
);

  localparam sgs_pkg::sgs_win_kind_e KIND = sgs_pkg::sgs_window_kind(LO, HI);

  logic [31:0] idx_w;
  assign idx_w = 32'(idx_i);

  if (!sgs_pkg::sgs_window_legal(LO, HI, LATENCY)) begin : g_illegal
    $error("guard window [%0d,%0d) does not fit a %0d-cycle group", LO, HI, LATENCY);
  end

  if (KIND == sgs_pkg::WIN_EMPTY) begin : g_empty
    // Zero-length window: never fires; the index is not needed here.
    logic unused_in;
    assign unused_in = busy_i ^ (^idx_w);
    assign hit_o = 1'b0;
  end else if (KIND == sgs_pkg::WIN_SINGLE) begin : g_single
    assign hit_o = busy_i && (idx_w == LO);
  end else begin : g_range
    assign hit_o = busy_i && sgs_pkg::sgs_in_window(idx_w, LO, HI);
  end

  // R6: a single-cycle window pulses for one cycle only (groups longer than one cycle).
  if (KIND == sgs_pkg::WIN_SINGLE && LATENCY > 1) begin : g_chk_single
    a_r6_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o);
  end

  // R6: an empty window stays low.
  if (KIND == sgs_pkg::WIN_EMPTY) begin : g_chk_empty
    a_r6_empty_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> !hit_o);
  end

endmodule

// File: rtl/sgs_guard_decoder.sv
module sgs_guard_decoder #(
  parameter int unsigned LATENCY    = 4,
  parameter int unsigned NUM_GUARDS = 3,
  parameter int unsigned GUARD_LO [NUM_GUARDS] = '{0, 3, 2},
  parameter int unsigned GUARD_HI [NUM_GUARDS] = '{3, 4, 2},
  localparam int unsigned CW = sgs_pkg::sgs_count_width(LATENCY)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busy_i,
  input  logic [CW-1:0]         idx_i,
  output logic [NUM_GUARDS-1:0] guard_o
);

  for (genvar g = 0; g < NUM_GUARDS; g++) begin : g_win
    sgs_guard_window #(
      .LATENCY (LATENCY),
      .LO      (GUARD_LO[g]),
      .HI      (GUARD_HI[g])
    ) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (busy_i),
      .idx_i  (idx_i),
      .hit_o  (guard_o[g])
    );
  end

endmodule

// File: rtl/static_group_sequencer.sv
module static_group_sequencer #(
  parameter int unsigned LATENCY    = 4,
  parameter int unsigned NUM_GUARDS = 3,
  parameter int unsigned GUARD_LO [NUM_GUARDS] = '{0, 3, 2},
  parameter int unsigned GUARD_HI [NUM_GUARDS] = '{3, 4, 2},
  localparam int unsigned CW = sgs_pkg::sgs_count_width(LATENCY)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  busy,
  output logic [CW-1:0]         cycle_idx,
  output logic                  last_cycle,
  output logic [NUM_GUARDS-1:0] guard
);

  localparam logic [CW-1:0] LAST_IDX = CW'(LATENCY - 1);

  logic launch_ev;
  logic finish_ev;

  sgs_cycle_counter #(.LATENCY(LATENCY)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .busy_o   (busy),
    .idx_o    (cycle_idx),
    .last_o   (last_cycle),
    .launch_o (launch_ev),
    .finish_o (finish_ev)
  );

  sgs_guard_decoder #(
    .LATENCY    (LATENCY),
    .NUM_GUARDS (NUM_GUARDS),
    .GUARD_LO   (GUARD_LO),
    .GUARD_HI   (GUARD_HI)
  ) u_decoder (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_i  (busy),
    .idx_i   (cycle_idx),
    .guard_o (guard)
  );

  // R2: an idle launch opens the group at index zero.
  a_r2_launch_zero : assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && cycle_idx == '0));

  // R4: without a new start the final cycle is followed by idle.
  a_r4_last_then_idle : assert property (@(posedge clk) disable iff (!rst_n)
    finish_ev |=> !busy);

  // R4: the final-cycle flag only appears at the top index.
  a_r4_last_at_top : assert property (@(posedge clk) disable iff (!rst_n)
    last_cycle |-> (busy && cycle_idx == LAST_IDX));

  // R7: a start in the final cycle relaunches with no gap.
  a_r7_relaunch : assert property (@(posedge clk) disable iff (!rst_n)
    (last_cycle && start) |=> (busy && cycle_idx == '0));

  // R8: a start in a middle cycle does not disturb the count.
  a_r8_mid_start_ignored : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_cycle && start) |=> (busy && cycle_idx == $past(cycle_idx) + CW'(1)));

  // R9: no guard fires while idle.
  a_r9_idle_guards_low : assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (guard == '0));

  // R2: every launch event is followed by a busy cycle.
  a_r2_launch_busy : assert property (@(posedge clk) disable iff (!rst_n)
    launch_ev |=> busy);

endmodule

// File: tb/static_group_sequencer_bench.sv
`timescale 1ns/100ps
module static_group_sequencer_bench;

  localparam int unsigned N  = 4;
  localparam int unsigned NG = 3;
  localparam int unsigned CW = 2;
  localparam int unsigned LO [NG] = '{0, 3, 2};
  localparam int unsigned HI [NG] = '{3, 4, 2};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy;
  logic [CW-1:0] cycle_idx;
  logic          last_cycle;
  logic [NG-1:0] guard;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          busy;
    int unsigned idx;
    bit          last;
    bit [NG-1:0] guard;
    string       tag;
  } exp_t;

  exp_t sb[$];

  // Bench model state
  bit          m_busy = 1'b0;
  int unsigned m_idx  = 0;

  always #2.5 clk = ~clk;

  static_group_sequencer u_static_group_sequencer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .cycle_idx  (cycle_idx),
    .last_cycle (last_cycle),
    .guard      (guard)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected guards from the window definitions: offset from lo below the window length.
  function automatic bit [NG-1:0] exp_guard(input bit b, input int unsigned i);
    bit [NG-1:0] r = '0;
    for (int g = 0; g < NG; g++)
      r[g] = b && (i - LO[g] < HI[g] - LO[g]) && (i >= LO[g]);
    return r;
  endfunction

  // Driver: drive start for one edge and push the state expected after it.
  task automatic drive(input bit s, input string tag);
    exp_t e;
    @(negedge clk);
    start = s;
    if (s && (!m_busy || m_idx == N - 1)) begin
      m_busy = 1'b1; m_idx = 0;
    end else if (m_busy && m_idx == N - 1) begin
      m_busy = 1'b0; m_idx = 0;
    end else if (m_busy) begin
      m_idx = m_idx + 1;
    end
    e.busy  = m_busy;
    e.idx   = m_idx;
    e.last  = m_busy && (m_idx == N - 1);
    e.guard = exp_guard(m_busy, m_idx);
    e.tag   = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare shortly after each edge.
  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(busy == e.busy, e.tag, "busy", int'(busy), int'(e.busy));
      check(int'(cycle_idx) == int'(e.idx), e.tag, "cycle_idx", int'(cycle_idx), int'(e.idx));
      check(last_cycle == e.last, "R4", "last_cycle", int'(last_cycle), int'(e.last));
      check(guard[0] == e.guard[0], e.busy ? "R5" : "R9", "guard0", int'(guard[0]), int'(e.guard[0]));
      check(guard[1] == e.guard[1], e.busy ? "R6" : "R9", "guard1", int'(guard[1]), int'(e.guard[1]));
      check(guard[2] == e.guard[2], "R6", "guard2", int'(guard[2]), int'(e.guard[2]));
    end
  end

  int g1_hits = 0;

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(cycle_idx == '0, "R1", "idx in reset", int'(cycle_idx), 0);
    check(last_cycle == 1'b0, "R1", "last in reset", int'(last_cycle), 0);
    check(guard == '0, "R1", "guards in reset", int'(guard), 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, "R1");

    // R2, R3: a single group, then idle
    drive(1'b1, "R2");
    for (int k = 0; k < 7; k++) drive(1'b0, "R3");

    // R7: start held high -> three back-to-back groups
    for (int k = 0; k < 3 * N; k++) drive(1'b1, "R7");
    drive(1'b0, "R7");
    for (int k = 0; k < 4; k++) drive(1'b0, "R9");

    // R8: starts in middle cycles are ignored
    drive(1'b1, "R2");
    drive(1'b1, "R8");
    drive(1'b0, "R8");
    drive(1'b1, "R8");
    drive(1'b0, "R8");
    drive(1'b0, "R8");

    // R7: a start exactly in the last cycle
    drive(1'b1, "R2");
    drive(1'b0, "R3");
    drive(1'b0, "R3");
    drive(1'b1, "R7");
    for (int k = 0; k < 6; k++) drive(1'b0, "R3");

    // R6: count single-cycle guard pulses over one isolated group
    drive(1'b1, "R2");
    for (int k = 0; k < N; k++) begin
      drive(1'b0, "R6");
      #1.5;
      if (guard[1]) g1_hits++;
    end
    drive(1'b0, "R9");
    check(g1_hits == 1, "R6", "guard1 pulses per group", g1_hits, 1);

    // R9: idle with no start keeps everything low
    for (int k = 0; k < 5; k++) drive(1'b0, "R9");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5 * 5000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule